// File: doc/BRIEF.md
# Flash Erase Unlock Sequencer

This block sits on the special-function-register write bus of a small microcontroller and turns register writes into erase and program commands for a flash array controller. It decodes three byte registers: a control register, a page-select register and a key register. An erase command is issued only when an arming step is followed by the matching key byte. A whole-array erase needs an arm bit in the control register followed by key 0xAA, and it is also gated by a debug-port-enable input. A single-page erase uses the page-select register followed by key 0x55. Any other key byte produces nothing.

A program-enable bit in the control register steers the processor's external data-store writes. When the bit is set, each write becomes a flash program request carrying the address and data. When it is clear, the write goes straight to the data-RAM strobe. Toward the flash controller the block raises a one-cycle request with a command code, an address and a data byte. It then stays busy until the controller returns a done pulse. While busy, new key writes and flash data writes are dropped.

The flash is 64 KB, arranged as 128 pages of 512 bytes each. The page-select register holds the page number in bits 7:1. Those bits become flash address bits 15:9, and the low nine address bits of a page erase are zero.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, busy and fl_req are 0, and the control and page registers both read back 0x00.
- R2: The control register (address 0xB2) reads back as {busy, 5'b0, mass_arm (bit 1), prog_en (bit 0)}. The page register (address 0xB7) reads back the written byte with bit 0 forced to 0. Any other read address returns 0x00.
- R3: Writing 0xAA to the key register (address 0x94) while mass_arm is 1, dbg_en is 1 and the block is idle gives fl_req for exactly one cycle, starting on the clock edge after the write. That request carries fl_cmd = 2'b01 (mass) and fl_addr = 0x0000.
- R4: A 0xAA key write with mass_arm set while dbg_en is 0 produces no request.
- R5: mass_arm clears on any accepted 0xAA key write, whether the erase is issued or rejected. A 0xAA write while mass_arm is 0 produces no request.
- R6: Writing 0x55 to the key register while idle issues a one-cycle request with fl_cmd = 2'b10 (page) and fl_addr = {page[7:1], 9'b0}.
- R7: A key byte other than 0x55 or 0xAA produces no request and leaves mass_arm unchanged.
- R8: With prog_en set, an external data write while idle issues a request with fl_cmd = 2'b11, together with the write's address and data, and ram_we stays 0. With prog_en clear, ram_we follows xw_we in the same cycle, ram_addr and ram_data pass through, and no request is made.
- R9: busy rises together with fl_req and falls on the clock edge after fl_done. While busy, key writes and flash data writes produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| sfr_raddr | input | 8 | Register read address |
| sfr_rdata | output | 8 | Register read data (combinational) |
| dbg_en | input | 1 | Debug port enabled; allows mass erase |
| xw_we | input | 1 | External data-store write strobe |
| xw_addr | input | 16 | External data-store write address |
| xw_data | input | 8 | External data-store write data |
| ram_we | output | 1 | Data-RAM write strobe |
| ram_addr | output | 16 | Data-RAM write address |
| ram_data | output | 8 | Data-RAM write data |
| fl_req | output | 1 | One-cycle flash command request |
| fl_cmd | output | 2 | 01 mass erase, 10 page erase, 11 program |
| fl_addr | output | 16 | Flash command address |
| fl_data | output | 8 | Flash program data |
| fl_done | input | 1 | Flash controller completion pulse |
| busy | output | 1 | Command outstanding |

## Verification
On every cycle the assertions check four things. A request starts only from idle, lasts one cycle and raises busy. busy falls only after a done pulse. A mass erase is issued only with the debug port enabled and always targets address zero. Page-erase addresses have their low nine bits clear, and a program request carries the data and program-enable state of the cycle before. Only the bench scenarios can show the decoding itself. The bench sweeps every key byte after arming and every page value, and it checks three further points: that the arm bit clears or persists as specified, that dropped writes during busy leave no trace, and that data writes are routed correctly to RAM or flash.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
   typedef enum logic [1:0] {
      FCMD_NONE  = 2'b00,
      FCMD_MASS  = 2'b01,
      FCMD_PAGE  = 2'b10,
      FCMD_WRITE = 2'b11
   } fcmd_t;

   localparam logic [7:0] KEY_MASS = 8'hAA;
   localparam logic [7:0] KEY_PAGE = 8'h55;

   localparam int CTRL_PWE_BIT  = 0;
   localparam int CTRL_ARM_BIT  = 1;
   localparam int CTRL_BUSY_BIT = 7;
endpackage

// File: rtl/fus_sfr_regs.sv
module fus_sfr_regs
   import flash_unlock_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          PNW       = 7,
   parameter logic [7:0]  ADDR_CTRL = 8'hB2,
   parameter logic [7:0]  ADDR_PAGE = 8'hB7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sfr_we,
   input  logic [7:0]     sfr_addr,
   input  logic [DW-1:0]  sfr_wdata,
   input  logic [7:0]     sfr_raddr,
   input  logic           arm_clr,
   input  logic           busy,
   output logic           pwe,
   output logic           arm,
   output logic [PNW-1:0] page_num,
   output logic [DW-1:0]  sfr_rdata
);
   localparam int LOWPAD = DW - PNW;

   logic wr_ctrl, wr_page;
   assign wr_ctrl = sfr_we && (sfr_addr == ADDR_CTRL);
   assign wr_page = sfr_we && (sfr_addr == ADDR_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwe      <= 1'b0;
         arm      <= 1'b0;
         page_num <= '0;
      end else begin
         if (wr_ctrl) begin
            pwe <= sfr_wdata[CTRL_PWE_BIT];
            arm <= sfr_wdata[CTRL_ARM_BIT];
         end else if (arm_clr) begin
            arm <= 1'b0;
         end
         if (wr_page)
            page_num <= sfr_wdata[DW-1 -: PNW];
      end
   end

   always_comb begin
      sfr_rdata = '0;
      if (sfr_raddr == ADDR_CTRL) begin
         sfr_rdata[CTRL_PWE_BIT]  = pwe;
         sfr_rdata[CTRL_ARM_BIT]  = arm;
         sfr_rdata[CTRL_BUSY_BIT] = busy;
      end else if (sfr_raddr == ADDR_PAGE) begin
         sfr_rdata = {page_num, {LOWPAD{1'b0}}};
      end
   end
endmodule

// File: rtl/fus_key_decode.sv
module fus_key_decode
   import flash_unlock_pkg::*;
#(
   parameter int         DW        = 8,
   parameter bit         MASS_GATE = 1'b1,
   parameter logic [7:0] ADDR_KEY  = 8'h94
) (
   input  logic          sfr_we,
   input  logic [7:0]    sfr_addr,
   input  logic [DW-1:0] sfr_wdata,
   input  logic          arm,
   input  logic          dbg_en,
   input  logic          busy,
   output logic          issue_mass,
   output logic          issue_page,
   output logic          arm_clr
);
   logic key_wr, is_mass_key, is_page_key, gate_ok;

   assign key_wr      = sfr_we && (sfr_addr == ADDR_KEY) && !busy;
   assign is_mass_key = (sfr_wdata[7:0] == KEY_MASS);
   assign is_page_key = (sfr_wdata[7:0] == KEY_PAGE);

   generate
      if (MASS_GATE) begin : g_gated
         assign gate_ok = dbg_en;
      end else begin : g_open
         assign gate_ok = 1'b1;
      end
   endgenerate

   assign arm_clr    = key_wr && is_mass_key && arm;
   assign issue_mass = arm_clr && gate_ok;
   assign issue_page = key_wr && is_page_key;
endmodule

// File: rtl/fus_req_engine.sv
module fus_req_engine
   import flash_unlock_pkg::*;
#(
   parameter int DW     = 8,
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 9,
   parameter int PNW    = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_mass,
   input  logic              issue_page,
   input  logic              issue_wr,
   input  logic [PNW-1:0]    page_num,
   input  logic [ADDR_W-1:0] xw_addr,
   input  logic [DW-1:0]     xw_data,
   input  logic              fl_done,
   output logic              fl_req,
   output fcmd_t             fl_cmd,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DW-1:0]     fl_data,
   output logic              busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         fl_req  <= 1'b0;
         fl_cmd  <= FCMD_NONE;
         fl_addr <= '0;
         fl_data <= '0;
      end else begin
         fl_req <= 1'b0;
         if (busy && fl_done)
            busy <= 1'b0;
         if (!busy) begin
            if (issue_mass) begin
               busy    <= 1'b1;
               fl_req  <= 1'b1;
               fl_cmd  <= FCMD_MASS;
               fl_addr <= '0;
               fl_data <= '0;
            end else if (issue_page) begin
               busy    <= 1'b1;
               fl_req  <= 1'b1;
               fl_cmd  <= FCMD_PAGE;
               fl_addr <= {page_num, {PAGE_W{1'b0}}};
               fl_data <= '0;
            end else if (issue_wr) begin
               busy    <= 1'b1;
               fl_req  <= 1'b1;
               fl_cmd  <= FCMD_WRITE;
               fl_addr <= xw_addr;
               fl_data <= xw_data;
            end
         end
      end
   end
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
   import flash_unlock_pkg::*;
#(
   parameter int         DW        = 8,
   parameter int         ADDR_W    = 16,
   parameter int         PAGE_W    = 9,
   parameter bit         MASS_GATE = 1'b1,
   parameter logic [7:0] ADDR_CTRL = 8'hB2,
   parameter logic [7:0] ADDR_PAGE = 8'hB7,
   parameter logic [7:0] ADDR_KEY  = 8'h94
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_we,
   input  logic [7:0]        sfr_addr,
   input  logic [DW-1:0]     sfr_wdata,
   input  logic [7:0]        sfr_raddr,
   output logic [DW-1:0]     sfr_rdata,
   input  logic              dbg_en,
   input  logic              xw_we,
   input  logic [ADDR_W-1:0] xw_addr,
   input  logic [DW-1:0]     xw_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DW-1:0]     ram_data,
   output logic              fl_req,
   output logic [1:0]        fl_cmd,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DW-1:0]     fl_data,
   input  logic              fl_done,
   output logic              busy
);
   localparam int PNW = ADDR_W - PAGE_W;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("flash_unlock_seq: DW must be 8");
      end
      if (PNW != DW - 1) begin : g_bad_pnw
         $error("flash_unlock_seq: page number must fill bits 7:1");
      end
   endgenerate

   logic           pwe_q, arm_q, arm_clr;
   logic [PNW-1:0] page_num;
   logic           issue_mass, issue_page, issue_wr;
   fcmd_t          cmd_q;

   fus_sfr_regs #(
      .DW(DW), .PNW(PNW), .ADDR_CTRL(ADDR_CTRL), .ADDR_PAGE(ADDR_PAGE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_raddr(sfr_raddr), .arm_clr(arm_clr),
      .busy(busy), .pwe(pwe_q), .arm(arm_q), .page_num(page_num),
      .sfr_rdata(sfr_rdata)
   );

   fus_key_decode #(
      .DW(DW), .MASS_GATE(MASS_GATE), .ADDR_KEY(ADDR_KEY)
   ) u_key (
      .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .arm(arm_q), .dbg_en(dbg_en), .busy(busy),
      .issue_mass(issue_mass), .issue_page(issue_page), .arm_clr(arm_clr)
   );

   // an erase key write in the same cycle wins; the data write is dropped
   assign issue_wr = xw_we && pwe_q && !busy && !issue_mass && !issue_page;

   assign ram_we   = xw_we && !pwe_q;
   assign ram_addr = xw_addr;
   assign ram_data = xw_data;

   fus_req_engine #(
      .DW(DW), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PNW(PNW)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .issue_mass(issue_mass),
      .issue_page(issue_page), .issue_wr(issue_wr), .page_num(page_num),
      .xw_addr(xw_addr), .xw_data(xw_data), .fl_done(fl_done),
      .fl_req(fl_req), .fl_cmd(cmd_q), .fl_addr(fl_addr),
      .fl_data(fl_data), .busy(busy)
   );

   assign fl_cmd = cmd_q;
endmodule

// File: rtl/fus_checker.sv
module fus_checker #(
   parameter int DW        = 8,
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 9,
   parameter bit MASS_GATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fl_req,
   input logic [1:0]        fl_cmd,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DW-1:0]     fl_data,
   input logic              fl_done,
   input logic              busy,
   input logic              dbg_en,
   input logic [DW-1:0]     xw_data,
   input logic              pwe
);
   AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> (busy && !$past(busy)));                              // R9
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req);                                             // R3
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fl_done));                                 // R9
   AST_MASS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_cmd == 2'b01) |-> ($past(dbg_en) || !MASS_GATE));  // R4
   AST_MASS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_cmd == 2'b01) |-> (fl_addr == '0));                // R3
   AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_cmd == 2'b10) |-> (fl_addr[PAGE_W-1:0] == '0));    // R6
   AST_WRITE_NEEDS_PWE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_cmd == 2'b11) |-> ($past(pwe) && fl_data == $past(xw_data))); // R8
endmodule

bind flash_unlock_seq fus_checker #(
   .DW(DW), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MASS_GATE(MASS_GATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fl_req(fl_req), .fl_cmd(fl_cmd),
   .fl_addr(fl_addr), .fl_data(fl_data), .fl_done(fl_done), .busy(busy),
   .dbg_en(dbg_en), .xw_data(xw_data), .pwe(pwe_q)
);

// File: tb/flash_unlock_seq_tb.sv
module flash_unlock_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'hB2;
   localparam logic [7:0] A_PAGE = 8'hB7;
   localparam logic [7:0] A_KEY  = 8'h94;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_we = 1'b0;
   logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_raddr = '0;
   logic [7:0]  sfr_rdata;
   logic        dbg_en = 1'b1;
   logic        xw_we = 1'b0;
   logic [15:0] xw_addr = '0;
   logic [7:0]  xw_data = '0;
   logic        ram_we;
   logic [15:0] ram_addr;
   logic [7:0]  ram_data;
   logic        fl_req;
   logic [1:0]  fl_cmd;
   logic [15:0] fl_addr;
   logic [7:0]  fl_data;
   logic        fl_done = 1'b0;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   int dcnt   = 0;
   logic done_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_unlock_seq u_dut (
      .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_raddr(sfr_raddr), .sfr_rdata(sfr_rdata),
      .dbg_en(dbg_en), .xw_we(xw_we), .xw_addr(xw_addr), .xw_data(xw_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
      .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_data(fl_data),
      .fl_done(fl_done), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // flash controller model: done pulse 8 cycles after a request
   always @(negedge clk) begin
      if (done_prev) chk("R9 busy clears after done", {31'b0, busy}, 32'd0);
      done_prev <= 1'b0;
      fl_done   <= 1'b0;
      if (dcnt != 0) begin
         dcnt <= dcnt - 1;
         if (dcnt == 1) begin
            chk("R9 busy held until done", {31'b0, busy}, 32'd1);
            fl_done   <= 1'b1;
            done_prev <= 1'b1;
         end
      end else if (fl_req) begin
         dcnt <= 8;
      end
   end

   task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
      @(negedge clk);
      sfr_we = 1'b0;
   endtask

   task automatic sfr_rd(input logic [7:0] a, output logic [7:0] d);
      sfr_raddr = a;
      #1;
      d = sfr_rdata;
   endtask

   task automatic xw_wr(input logic [15:0] a, input logic [7:0] d, output logic rw,
                        output logic [15:0] ra, output logic [7:0] rd);
      @(negedge clk);
      xw_we = 1'b1; xw_addr = a; xw_data = d;
      #1;
      rw = ram_we; ra = ram_addr; rd = ram_data;
      @(negedge clk);
      xw_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 40 && (busy || dcnt != 0 || done_prev); i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0]  rd;
      logic        rw;
      logic [15:0] ra;
      logic [7:0]  rdat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", {31'b0, busy}, 0);
      chk("R1 fl_req", {31'b0, fl_req}, 0);
      sfr_rd(A_CTRL, rd); chk("R1 ctrl", {24'b0, rd}, 0);
      sfr_rd(A_PAGE, rd); chk("R1 page", {24'b0, rd}, 0);

      // R2 readback sweep of the page register
      for (int v = 0; v < 256; v++) begin
         sfr_wr(A_PAGE, v[7:0]);
         sfr_rd(A_PAGE, rd);
         chk("R2 page readback", {24'b0, rd}, v & 32'hFE);
      end
      sfr_wr(A_CTRL, 8'h03); sfr_rd(A_CTRL, rd); chk("R2 ctrl readback", {24'b0, rd}, 32'h03);
      sfr_wr(A_CTRL, 8'h00); sfr_rd(A_CTRL, rd); chk("R2 ctrl cleared", {24'b0, rd}, 32'h00);
      sfr_rd(8'h11, rd); chk("R2 unmapped read", {24'b0, rd}, 0);

      // R3 R5 R6 R7 sweep every key byte after arming
      dbg_en = 1'b1;
      for (int b = 0; b < 256; b++) begin
         logic exp_req;
         sfr_wr(A_PAGE, 8'h5A);
         sfr_wr(A_CTRL, 8'h02);
         sfr_wr(A_KEY, b[7:0]);
         exp_req = (b == 32'hAA) || (b == 32'h55);
         chk("R7 key sweep request", {31'b0, fl_req}, {31'b0, exp_req});
         if (b == 32'hAA) begin
            chk("R3 mass cmd", {30'b0, fl_cmd}, 1);
            chk("R3 mass addr", {16'b0, fl_addr}, 0);
         end
         if (b == 32'h55) begin
            chk("R6 page cmd", {30'b0, fl_cmd}, 2);
            chk("R6 page addr", {16'b0, fl_addr}, 32'h5A00);
         end
         @(negedge clk);
         chk("R3 request one cycle", {31'b0, fl_req}, 0);
         wait_idle();
         sfr_rd(A_CTRL, rd);
         chk("R5 arm after key", {31'b0, rd[1]}, (b == 32'hAA) ? 0 : 1);
      end
      sfr_wr(A_CTRL, 8'h00);

      // R6 page address sweep
      for (int p = 0; p < 256; p++) begin
         sfr_wr(A_PAGE, p[7:0]);
         sfr_wr(A_KEY, 8'h55);
         chk("R6 page sweep req", {31'b0, fl_req}, 1);
         chk("R6 page sweep addr", {16'b0, fl_addr}, (p >> 1) << 9);
         wait_idle();
      end

      // R4 mass rejected without debug port; arm still consumed
      dbg_en = 1'b0;
      sfr_wr(A_CTRL, 8'h02);
      sfr_wr(A_KEY, 8'hAA);
      chk("R4 no mass without dbg", {31'b0, fl_req}, 0);
      @(negedge clk);
      chk("R4 stays idle", {31'b0, busy}, 0);
      sfr_rd(A_CTRL, rd); chk("R5 arm cleared on reject", {31'b0, rd[1]}, 0);
      dbg_en = 1'b1;
      sfr_wr(A_KEY, 8'hAA);
      chk("R5 no mass without arm", {31'b0, fl_req}, 0);
      @(negedge clk);
      chk("R5 stays idle", {31'b0, busy}, 0);

      // R8 routing of data writes
      for (int k = 0; k < 8; k++) begin
         logic [15:0] a;
         logic [7:0]  d;
         a = 16'h1234 * (k + 1) + 16'h0F0F * k;
         d = 8'h3C ^ (k * 8'h27);
         sfr_wr(A_CTRL, 8'h01);
         xw_wr(a, d, rw, ra, rdat);
         chk("R8 no ram write when pwe", {31'b0, rw}, 0);
         chk("R8 flash write req", {31'b0, fl_req}, 1);
         chk("R8 flash write cmd", {30'b0, fl_cmd}, 3);
         chk("R8 flash write addr", {16'b0, fl_addr}, {16'b0, a});
         chk("R8 flash write data", {24'b0, fl_data}, {24'b0, d});
         wait_idle();
         sfr_wr(A_CTRL, 8'h00);
         xw_wr(a ^ 16'hFFFF, ~d, rw, ra, rdat);
         chk("R8 ram strobe", {31'b0, rw}, 1);
         chk("R8 ram addr", {16'b0, ra}, {16'b0, a ^ 16'hFFFF});
         chk("R8 ram data", {24'b0, rdat}, {24'b0, ~d});
         chk("R8 no flash req when ram", {31'b0, fl_req}, 0);
      end

      // R9 writes dropped while busy
      sfr_wr(A_PAGE, 8'h10);
      sfr_wr(A_KEY, 8'h55);
      chk("R9 first req", {31'b0, fl_req}, 1);
      sfr_rd(A_CTRL, rd); chk("R9 busy readback", {31'b0, rd[7]}, 1);
      sfr_wr(A_KEY, 8'h55);
      chk("R9 key ignored while busy", {31'b0, fl_req}, 0);
      sfr_wr(A_CTRL, 8'h01);
      xw_wr(16'hBEEF, 8'h77, rw, ra, rdat);
      chk("R9 data write ignored while busy", {31'b0, fl_req}, 0);
      chk("R9 no ram while busy with pwe", {31'b0, rw}, 0);
      wait_idle();
      sfr_rd(A_CTRL, rd); chk("R9 idle after done", {31'b0, rd[7]}, 0);
      sfr_wr(A_CTRL, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule